// File: doc/BRIEF.md
# System Tick Countdown Timer

A periodic down-counter with a small register file. Software stores a reload value, zeroes the count, then turns the timer on. While it runs, the count steps down by one on every selected tick and, after reaching zero, takes the reload value again. A reload value of N-1 therefore gives a wrap every N ticks. Each step from 1 to 0 sets a sticky wrap flag and, if interrupts are on, raises a one-cycle interrupt pulse.

The tick comes from one of two places: every core clock cycle, or each rising edge of an external reference signal. The reference is brought into the clock domain through a synchronizer. A read-only calibration word is fixed by a parameter. It reports whether a reference exists, whether its 10 ms value is exact, and the reload value for a 10 ms period.

The bus uses a word index, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control word, reload and count read as 0, the calibration word reads as its parameter value, and the interrupt output is low.
- R2: Word index 0 selects control, 1 selects reload, 2 selects the count and 3 selects calibration. Writes to index 3 are ignored. Reload and count read with bits 31:24 as zero. Control bits other than 0, 1, 2 and 16 read as zero.
- R3: While control bit 0 (run) is clear, the count holds its value.
- R4: Control bit 2 set selects the core clock as the tick source. On each tick the count steps down, or loads the reload value when it is 0. A reload value of N-1 gives a period of N ticks.
- R5: Any write to the count register sets the count to 0 and clears the wrap flag. This takes priority over a tick in the same cycle.
- R6: Control bit 16 is set when the count steps from 1 to 0. It stays set across further wraps. A read of the control register returns the flag and then clears it.
- R7: If control bit 1 is set, each wrap gives a one-cycle pulse on the interrupt output. If bit 1 is clear, no pulse is produced.
- R8: Control bit 2 clear selects the external reference. The count then advances once per rising edge of the synchronized reference, however long the input stays high.
- R9: A reload value of 0 keeps the count at 0 and never sets the wrap flag.
- R10: A newly written reload value does not change the count in progress. It is used at the next load from 0.
- R11: The calibration word reads back the module parameter unchanged. The default is 0x4000_2710: bit 31 clear (reference present), bit 30 set (value not exact), bits 23:0 equal to 10000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 2 | Register word index (byte offset divided by 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| ref_tick_in | input | 1 | Asynchronous external reference |
| tick_irq | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
The assertions check four properties on every cycle:
- The count holds while the timer is stopped.
- Each tick from a nonzero count steps it down by exactly one.
- A count write forces zero, and a zero reload keeps the count at zero.
- The flag follows wraps and status reads, and an interrupt pulse lasts one cycle and always comes with a set flag.

Several behaviours only the bench scenarios can show. These are the exact period for a given reload value, and a reload change that waits for the next load. The others are a count write that beats a coinciding wrap, and a single count per rising edge of a long reference pulse.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      SEL_CTL = 2'd0,
      SEL_RLD = 2'd1,
      SEL_CNT = 2'd2,
      SEL_CAL = 2'd3
   } reg_sel_e;

   localparam int unsigned RUN_BIT  = 0;
   localparam int unsigned IRQ_BIT  = 1;
   localparam int unsigned SRC_BIT  = 2;
   localparam int unsigned WRAP_BIT = 16;

   typedef struct packed {
      logic core_src;
      logic irq_on;
      logic run;
   } ctl_t;

endpackage

// File: rtl/tick_src.sv
module tick_src #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic core_sel,
   output logic tick
);

   localparam int unsigned TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   ext_tick;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tick_src: SYNC_STAGES must be at least 2");
      end
      if (SYNC_STAGES == 2) begin : g_sync_two
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], ref_in};
         end
      end else begin : g_sync_long
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ref_in};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[TOP];
   end

   assign ext_tick = sync_q[TOP] & ~prev_q;
   assign tick     = core_sel ? 1'b1 : ext_tick;

   AST_EXT_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_sel && tick) |=> !(!core_sel && tick && $stable(core_sel))); // R8

endmodule

// File: rtl/tick_core.sv
module tick_core #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             clr,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic step;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tick_core: CNT_W must be at least 2");
      end
   endgenerate

   assign step = run & tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (step) begin
         if (cnt == '0) cnt <= reload;
         else           cnt <= cnt - CNT_ONE;
      end
   end

   assign wrap = step & ~clr & (cnt == CNT_ONE);

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R5

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt)); // R3

   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !clr && cnt != '0) |=> (cnt == $past(cnt) - CNT_ONE)); // R4

   AST_ZERO_RELOAD_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
      (reload == '0 && cnt == '0) |=> (cnt == '0)); // R9

endmodule

// File: rtl/tick_regfile.sv
module tick_regfile
   import tick_timer_pkg::*;
#(
   parameter int unsigned              DATA_W     = 32,
   parameter int unsigned              CNT_W      = 24,
   parameter logic [DATA_W-1:0]        CALIB_WORD = 32'h4000_2710
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        word,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   output logic [DATA_W-1:0] rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              wrap,
   output ctl_t              ctl,
   output logic [CNT_W-1:0]  reload,
   output logic              clr,
   output logic              irq
);

   reg_sel_e          sel;
   logic              flag_q;
   logic              ctl_rd;
   logic [DATA_W-1:0] rd_mux;
   logic              wdata_unused;

   generate
      if (DATA_W <= WRAP_BIT || CNT_W >= DATA_W) begin : g_bad_width
         $error("tick_regfile: need DATA_W > 16 and CNT_W < DATA_W");
      end
   endgenerate

   assign sel          = reg_sel_e'(word);
   assign clr          = we && (sel == SEL_CNT);
   assign ctl_rd       = re && (sel == SEL_CTL);
   assign wdata_unused = ^wdata[DATA_W-1:CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl    <= '0;
         reload <= '0;
      end else if (we) begin
         if (sel == SEL_CTL) begin
            ctl.run      <= wdata[RUN_BIT];
            ctl.irq_on   <= wdata[IRQ_BIT];
            ctl.core_src <= wdata[SRC_BIT];
         end
         if (sel == SEL_RLD) reload <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (clr)    flag_q <= 1'b0;
      else if (wrap)   flag_q <= 1'b1;
      else if (ctl_rd) flag_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= wrap & ctl.irq_on;
   end

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_CTL: begin
            rd_mux[RUN_BIT]  = ctl.run;
            rd_mux[IRQ_BIT]  = ctl.irq_on;
            rd_mux[SRC_BIT]  = ctl.core_src;
            rd_mux[WRAP_BIT] = flag_q;
         end
         SEL_RLD: rd_mux = DATA_W'(reload);
         SEL_CNT: rd_mux = DATA_W'(cnt);
         SEL_CAL: rd_mux = CALIB_WORD;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= rd_mux;
   end

   AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd && !wrap) |=> !flag_q); // R6

   AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag_q); // R6

   AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag_q); // R7

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R7

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       CNT_W       = 24,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] CALIB_WORD  = 32'h4000_2710
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_word,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ref_tick_in,
   output logic              tick_irq
);

   ctl_t             ctl;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt;
   logic             clr;
   logic             wrap;
   logic             tick;

   tick_regfile #(
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .CALIB_WORD (CALIB_WORD)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .word   (bus_word),
      .we     (bus_we),
      .wdata  (bus_wdata),
      .re     (bus_re),
      .rdata  (bus_rdata),
      .cnt    (cnt),
      .wrap   (wrap),
      .ctl    (ctl),
      .reload (reload),
      .clr    (clr),
      .irq    (tick_irq)
   );

   tick_src #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_in   (ref_tick_in),
      .core_sel (ctl.core_src),
      .tick     (tick)
   );

   tick_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctl.run),
      .tick   (tick),
      .clr    (clr),
      .reload (reload),
      .cnt    (cnt),
      .wrap   (wrap)
   );

endmodule

// File: tb/sys_tick_timer_test.sv
module sys_tick_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] CAL = 32'h4000_2710;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_word = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        ref_tick_in = 1'b0;
   logic        tick_irq;

   int total = 0;
   int bad = 0;
   logic re_seen = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   sys_tick_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .ref_tick_in(ref_tick_in), .tick_irq(tick_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per accepted read
   always @(posedge clk) re_seen <= bus_re;
   always @(negedge clk) begin
      if (re_seen) begin
         if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   // driver tasks: start at a falling edge, occupy one rising edge
   task automatic wr(input logic [1:0] w, input logic [31:0] d);
      bus_word = w; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] w, input logic [31:0] exp, input string tag);
      bus_word = w; bus_re = 1'b1; bus_we = 1'b0;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int pulses;
      logic last;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq low", {31'd0, tick_irq}, 32'd0);
      rd(2'd0, 32'd0, "R1 control");
      rd(2'd1, 32'd0, "R1 reload");
      rd(2'd2, 32'd0, "R1 count");
      rd(2'd3, CAL, "R1 calib");

      // R2 / R11 map, masks, read-only calibration
      wr(2'd3, 32'h1234_5678);
      rd(2'd3, CAL, "R11 calib after write");
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, 32'h00FF_FFFF, "R2 reload upper bits");
      wr(2'd0, 32'hFFFF_FFF8);
      rd(2'd0, 32'd0, "R2 control unused bits");

      // R4 / R6 period of 5 with reload 4, flag read-clear
      wr(2'd1, 32'd4); wr(2'd2, 32'd0); wr(2'd0, 32'h5);
      rd(2'd2, 32'd0, "R4 seq0");
      rd(2'd2, 32'd4, "R4 seq1");
      rd(2'd2, 32'd3, "R4 seq2");
      rd(2'd2, 32'd2, "R4 seq3");
      rd(2'd2, 32'd1, "R4 seq4");
      rd(2'd2, 32'd0, "R4 seq5");
      rd(2'd2, 32'd4, "R4 seq6");
      rd(2'd0, 32'h0001_0005, "R6 flag set");
      rd(2'd0, 32'h0000_0005, "R6 flag cleared by read");
      wr(2'd0, 32'h0);

      // R3 hold while stopped
      wr(2'd1, 32'd9); wr(2'd2, 32'd0); wr(2'd0, 32'h5);
      idle(2);
      wr(2'd0, 32'h0);
      idle(5);
      rd(2'd2, 32'd7, "R3 count held");
      rd(2'd0, 32'd0, "R3 status stopped");

      // R10 late reload change, R5 count write beats wrap
      wr(2'd1, 32'd9); wr(2'd2, 32'd0); wr(2'd0, 32'h5);
      idle(2);
      wr(2'd1, 32'd2);
      rd(2'd2, 32'd7, "R10 old period continues a");
      rd(2'd2, 32'd6, "R10 old period continues b");
      rd(2'd2, 32'd5, "R10 c");
      rd(2'd2, 32'd4, "R10 d");
      rd(2'd2, 32'd3, "R10 e");
      rd(2'd2, 32'd2, "R10 f");
      rd(2'd2, 32'd1, "R10 g");
      rd(2'd2, 32'd0, "R10 h");
      rd(2'd2, 32'd2, "R10 new reload used");
      wr(2'd2, 32'hDEAD_BEEF);
      rd(2'd0, 32'h0000_0005, "R5 flag cleared by count write");
      rd(2'd2, 32'd2, "R5 restart from zero");
      wr(2'd0, 32'h0);

      // R7 interrupt pulses with bit 1 set
      wr(2'd1, 32'd2); wr(2'd2, 32'd0); wr(2'd0, 32'h7);
      pulses = 0; last = 1'b0;
      for (int i = 0; i < 10; i++) begin
         if (tick_irq) pulses++;
         if (tick_irq && last) chk("R7 pulse width", 32'd2, 32'd1);
         last = tick_irq;
         @(negedge clk);
      end
      chk("R7 pulse count enabled", pulses, 32'd3);
      wr(2'd0, 32'h5);
      pulses = 0;
      for (int i = 0; i < 10; i++) begin
         if (tick_irq) pulses++;
         @(negedge clk);
      end
      chk("R7 no pulses when disabled", pulses, 32'd0);
      rd(2'd0, 32'h0001_0005, "R7 flag still set without irq");
      wr(2'd0, 32'h0);

      // R9 zero reload
      wr(2'd1, 32'd0); wr(2'd2, 32'd0); wr(2'd0, 32'h7);
      pulses = 0;
      for (int i = 0; i < 8; i++) begin
         if (tick_irq) pulses++;
         @(negedge clk);
      end
      chk("R9 no irq", pulses, 32'd0);
      rd(2'd2, 32'd0, "R9 count stays zero");
      rd(2'd0, 32'h0000_0007, "R9 no flag");
      wr(2'd0, 32'h0);

      // R8 external reference edges
      wr(2'd1, 32'd20); wr(2'd2, 32'd0); wr(2'd0, 32'h1);
      idle(4);
      for (int i = 0; i < 2; i++) begin
         ref_tick_in = 1'b1; idle(4);
         ref_tick_in = 1'b0; idle(4);
      end
      ref_tick_in = 1'b1; idle(12);
      ref_tick_in = 1'b0; idle(6);
      rd(2'd2, 32'd18, "R8 one count per edge");
      rd(2'd0, 32'h0000_0001, "R8 external mode status");

      idle(3);
      if (exp_q.size() != 0) chk("scoreboard drained", exp_q.size(), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule